// File: doc/BRIEF.md
# Super-bank block mapper

This block widens a four-block memory banking scheme (four 64K blocks, 256K in total) to eight physical 64K blocks (512K). Two bits of an existing bank configuration register were previously unused. The block captures them as a 2-bit mode whenever the CPU writes that register. The mode then steers the 2-bit logical block number from the existing steering logic onto a 3-bit physical block number.

The same write also captures two spare bits of the register and presents them as general-purpose outputs. Mode 00 is plain 256K operation, and reset returns to it. Two modes move only the upper logical pair, blocks 2 and 3, into one of the added physical pairs. The remaining mode maps all four logical blocks to the second 256K, which gives a complete alternate set so the system can keep two separate contexts.

A parameter selects a reduced build for systems with no added RAM. In that build the physical block stays inside the first 256K, and the alternate mode exchanges logical blocks 0–1 with 2–3.

Top module: `superbank_mapper`

## Requirements
- R1: While rst_ni is low, mode_o reads 00 and spare_o reads 00.
- R2: At a rising clock edge where cfg_sel_i is high and rw_i is low, data_i bits 5:4 are stored as the mode. mode_o and pblk_o show the new value from that edge onward.
- R3: mode_o and spare_o keep their values at any edge where cfg_sel_i is low or rw_i is high, whatever data_i holds.
- R4: The same write that stores the mode also stores data_i bits 7:6 into spare_o.
- R5: In mode 00, pblk_o equals the logical block with a leading 0 (logical n maps to physical n).
- R6: In mode 01, logical blocks 0 and 1 map to themselves, and logical blocks 2 and 3 map to physical 4 and 5.
- R7: In mode 10, logical blocks 0 and 1 map to themselves, and logical blocks 2 and 3 map to physical 6 and 7.
- R8: In mode 11, logical block n maps to physical block n+4.
- R9: pblk_o follows a change of lblk_i within the same cycle, with no register in that path.
- R10: With REDUCED=1, mode 11 maps logical n to n XOR 2, every other mode is identity, and pblk_o bit 2 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | CPU data bus |
| rw_i | input | 1 | 1 = read, 0 = write |
| cfg_sel_i | input | 1 | Decode strobe for the bank configuration register, active high |
| lblk_i | input | 2 | Logical block select from the four-block steering logic |
| pblk_o | output | 3 | Physical block select |
| mode_o | output | 2 | Latched super-bank mode |
| spare_o | output | 2 | Latched spare bits, available for general use |

## Verification
The bench writes each of the four modes in turn and then walks all four logical blocks under each one. This separates the three upper-pair maps from one another and from the full alternate map, and it also shows that blocks 0 and 1 stay put in modes 01 and 10. Some register cycles change data_i while cfg_sel_i is high but rw_i is high, and others while rw_i is low but cfg_sel_i is low. If either qualifier were lost, the mode would change on those cycles. The spare bits are written with values that differ from the mode bits, so a swapped data field shows up. A second instance built with REDUCED=1 receives the same traffic, so the exchange map can be checked side by side with the full map.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    MODE_BASE   = 2'b00,
    MODE_PAIR_A = 2'b01,
    MODE_PAIR_B = 2'b10,
    MODE_ALT    = 2'b11
  } sb_mode_e;
endpackage

// File: rtl/sb_wr_qual.sv
module sb_wr_qual (
  input  logic sel_i,
  input  logic rw_i,
  output logic wr_en_o
);
  assign wr_en_o = sel_i & ~rw_i;
endmodule

// File: rtl/sb_cfg_latch.sv
module sb_cfg_latch
  import sb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MODE_LSB  = 4,
  parameter int SPARE_LSB = 6,
  parameter int FIELD_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                wr_en_i,
  output sb_mode_e            mode_o,
  output logic [FIELD_W-1:0]  spare_o
);
  sb_mode_e            mode_q;
  logic [FIELD_W-1:0]  spare_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_BASE;
      spare_q <= '0;
    end else if (wr_en_i) begin
      mode_q  <= sb_mode_e'(data_i[MODE_LSB +: FIELD_W]);
      spare_q <= data_i[SPARE_LSB +: FIELD_W];
    end
  end

  assign mode_o  = mode_q;
  assign spare_o = spare_q;
endmodule

// File: rtl/sb_block_map.sv
module sb_block_map
  import sb_pkg::*;
#(
  parameter int LBLK_W  = 2,
  parameter bit REDUCED = 1'b0,
  localparam int PBLK_W = LBLK_W + 1
) (
  input  sb_mode_e             mode_i,
  input  logic [LBLK_W-1:0]    lblk_i,
  output logic [PBLK_W-1:0]    pblk_o
);
  localparam logic [LBLK_W-1:0] MSB_MASK = 1 << (LBLK_W - 1);

  logic upper;
  assign upper = lblk_i[LBLK_W-1];

  generate
    if (REDUCED) begin : g_reduced
      // no added RAM: alternate mode exchanges lower and upper halves
      always_comb begin
        if (mode_i == MODE_ALT) pblk_o = {1'b0, lblk_i ^ MSB_MASK};
        else                    pblk_o = {1'b0, lblk_i};
      end
    end else begin : g_full
      always_comb begin
        unique case (mode_i)
          MODE_BASE:   pblk_o = {1'b0, lblk_i};
          MODE_PAIR_A: pblk_o = upper ? {1'b1, lblk_i & ~MSB_MASK} : {1'b0, lblk_i};
          MODE_PAIR_B: pblk_o = {upper, lblk_i};
          MODE_ALT:    pblk_o = {1'b1, lblk_i};
          default:     pblk_o = {1'b0, lblk_i};
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/superbank_mapper.sv
module superbank_mapper
  import sb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MODE_LSB  = 4,
  parameter int SPARE_LSB = 6,
  parameter int LBLK_W    = 2,
  parameter bit REDUCED   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rw_i,
  input  logic              cfg_sel_i,
  input  logic [LBLK_W-1:0] lblk_i,
  output logic [LBLK_W:0]   pblk_o,
  output logic [1:0]        mode_o,
  output logic [1:0]        spare_o
);
  sb_mode_e mode_q;
  logic     wr_en;

  sb_wr_qual u_wr_qual (
    .sel_i   (cfg_sel_i),
    .rw_i    (rw_i),
    .wr_en_o (wr_en)
  );

  sb_cfg_latch #(
    .DATA_W    (DATA_W),
    .MODE_LSB  (MODE_LSB),
    .SPARE_LSB (SPARE_LSB),
    .FIELD_W   (2)
  ) u_cfg_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .wr_en_i (wr_en),
    .mode_o  (mode_q),
    .spare_o (spare_o)
  );

  sb_block_map #(
    .LBLK_W  (LBLK_W),
    .REDUCED (REDUCED)
  ) u_block_map (
    .mode_i (mode_q),
    .lblk_i (lblk_i),
    .pblk_o (pblk_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/superbank_mapper_chk.sv
module superbank_mapper_chk #(
  parameter int DATA_W    = 8,
  parameter int MODE_LSB  = 4,
  parameter int SPARE_LSB = 6,
  parameter int LBLK_W    = 2,
  parameter bit REDUCED   = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              rw_i,
  input logic              cfg_sel_i,
  input logic [LBLK_W-1:0] lblk_i,
  input logic [LBLK_W:0]   pblk_o,
  input logic [1:0]        mode_o,
  input logic [1:0]        spare_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (mode_o == 2'b00 && spare_o == 2'b00);
    end
  end

  p_write_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel_i && !rw_i) |=> mode_o == $past(data_i[MODE_LSB +: 2]));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_sel_i && !rw_i) |=> ($stable(mode_o) && $stable(spare_o)));

  p_spare_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel_i && !rw_i) |=> spare_o == $past(data_i[SPARE_LSB +: 2]));

  p_identity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00) |-> pblk_o == {1'b0, lblk_i});

  p_low_pair_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!REDUCED && (mode_o == 2'b01 || mode_o == 2'b10) && !lblk_i[LBLK_W-1])
      |-> pblk_o == {1'b0, lblk_i});

  p_alt_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!REDUCED && mode_o == 2'b11) |-> pblk_o == {1'b1, lblk_i});

  p_reduced_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    REDUCED |-> !pblk_o[LBLK_W]);
endmodule

bind superbank_mapper superbank_mapper_chk #(
  .DATA_W    (DATA_W),
  .MODE_LSB  (MODE_LSB),
  .SPARE_LSB (SPARE_LSB),
  .LBLK_W    (LBLK_W),
  .REDUCED   (REDUCED)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .rw_i      (rw_i),
  .cfg_sel_i (cfg_sel_i),
  .lblk_i    (lblk_i),
  .pblk_o    (pblk_o),
  .mode_o    (mode_o),
  .spare_o   (spare_o)
);

// File: tb/superbank_mapper_bench.sv
module superbank_mapper_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       rw_i = 1'b1;
  logic       cfg_sel_i = 1'b0;
  logic [1:0] lblk_i = 2'd0;
  logic [2:0] pblk_o, pblk_red;
  logic [1:0] mode_o, mode_red, spare_o, spare_red;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  int ref_mode = 0;
  int ref_spare = 0;
  bit last_wr = 0;
  int ref_tbl [4][4];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  superbank_mapper u_superbank_mapper (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .rw_i(rw_i),
    .cfg_sel_i(cfg_sel_i), .lblk_i(lblk_i), .pblk_o(pblk_o),
    .mode_o(mode_o), .spare_o(spare_o)
  );

  superbank_mapper #(.REDUCED(1'b1)) u_superbank_mapper_red (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .rw_i(rw_i),
    .cfg_sel_i(cfg_sel_i), .lblk_i(lblk_i), .pblk_o(pblk_red),
    .mode_o(mode_red), .spare_o(spare_red)
  );

  function automatic int ref_reduced(int m, int l);
    return (m == 3) ? (l ^ 2) : l;
  endfunction

  function automatic string map_tag(int m);
    case (m)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(int got, int exp, string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d at t=%0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_mode = 0; ref_spare = 0; last_wr = 0;
    end else begin
      last_wr = cfg_sel_i && !rw_i;
      if (last_wr) begin
        ref_mode  = int'(data_i[5:4]);
        ref_spare = int'(data_i[7:6]);
      end
    end
  end

  // compare every clock
  always @(negedge clk_i) begin
    if (!done) begin
      if (!rst_ni) begin
        chk(mode_o, 0, "R1");
        chk(spare_o, 0, "R1");
      end else begin
        chk(mode_o, ref_mode, last_wr ? "R2" : "R3");
        chk(spare_o, ref_spare, last_wr ? "R4" : "R3");
        chk(pblk_o, ref_tbl[ref_mode][lblk_i], map_tag(ref_mode));
        chk(pblk_red, ref_reduced(ref_mode, lblk_i), "R10");
      end
    end
  end

  task automatic bus(bit sel, bit rw, logic [7:0] d, logic [1:0] l);
    @(negedge clk_i);
    #2;
    cfg_sel_i = sel; rw_i = rw; data_i = d; lblk_i = l;
  endtask

  task automatic write_mode(int m, int s);
    bus(1'b1, 1'b0, {2'(s), 2'(m), 4'hA}, lblk_i);
    bus(1'b0, 1'b1, 8'h00, lblk_i);
  endtask

  initial begin
    ref_tbl[0] = '{0, 1, 2, 3};
    ref_tbl[1] = '{0, 1, 4, 5};
    ref_tbl[2] = '{0, 1, 6, 7};
    ref_tbl[3] = '{4, 5, 6, 7};

    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;

    // walk every mode and every logical block
    for (int m = 0; m < 4; m++) begin
      write_mode(m, 3 - m);
      for (int l = 0; l < 4; l++) begin
        bus(1'b0, 1'b1, 8'h00, 2'(l));
        #1 chk(pblk_o, ref_tbl[m][l], "R9");
      end
    end

    // reads and unselected writes must not disturb the latch (R3)
    write_mode(2, 1);
    bus(1'b1, 1'b1, 8'hF0, 2'd3);
    bus(1'b1, 1'b1, 8'h30, 2'd2);
    bus(1'b0, 1'b0, 8'hFF, 2'd3);
    bus(1'b0, 1'b0, 8'h10, 2'd2);
    bus(1'b0, 1'b1, 8'h00, 2'd3);
    #1 chk(mode_o, 2, "R3");
    chk(spare_o, 1, "R3");
    chk(pblk_o, 7, "R7");

    // back-to-back writes (R2)
    bus(1'b1, 1'b0, 8'h70, 2'd1);
    bus(1'b1, 1'b0, 8'h90, 2'd2);
    bus(1'b1, 1'b0, 8'h20, 2'd3);
    bus(1'b0, 1'b1, 8'h00, 2'd3);

    // change of lblk within a cycle in alternate mode (R9)
    write_mode(3, 2);
    for (int l = 3; l >= 0; l--) begin
      #1 lblk_i = 2'(l);
      #1 chk(pblk_o, l + 4, "R9");
      chk(pblk_red, l ^ 2, "R10");
    end

    // mid-run reset returns to base mode (R1)
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    #2 rst_ni = 1'b1;
    bus(1'b0, 1'b1, 8'h00, 2'd2);
    #1 chk(pblk_o, 2, "R1");
    repeat (2) @(negedge clk_i);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: got=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule